// File: doc/BRIEF.md
# I2C Single-Byte Master Controller

This block is a master-only I2C controller for a single-master bus. A host starts a transfer through a strobe-based parallel port: chip-select plus a read strobe or a write strobe, together with a 3-bit device address and, for writes, an 8-bit data byte. Each request moves exactly one byte. The controller sends START, then the address byte and its acknowledge slot, then the data byte and its acknowledge slot, then STOP.

The bus lines are open-drain. The controller only produces drive-low enables for SCL and SDA and reads both lines back. One speed input picks a bit rate of 100 kbit/s or 400 kbit/s. Both rates are derived from the system clock through a quarter-period timer, and each SCL period is split into four equal quarters. A slave that holds SCL low stalls the timer. A busy flag covers the whole transfer. A missing acknowledge ends the transfer early and leaves a sticky error status. Requests that assert both strobes at once are rejected with a one-cycle error pulse.

Top module: `i2c_one_byte_ctrl`

## Requirements
- R1: After reset, busy, req_err and nack_err are 0, rdata is 0x00, and neither bus line is driven (scl_oe = sda_oe = 0).
- R2: A request is taken when the block is idle, cs is 1, exactly one of rd or wr is 1, and both bus lines read high. busy is 1 from the next clock until the STOP condition has completed.
- R3: cs with rd and wr both 1 is ignored: no transfer starts, the bus stays released, and req_err is 1 for one clock, in the cycle after the strobes.
- R4: A request made while either bus line reads low is ignored without an error. busy stays 0 and nothing is driven.
- R5: Every transfer has exactly one START and one STOP. The first byte sent is {ADDR_PREFIX (default 4'b1010), addr[2:0], dir}, MSB first, where dir is 1 for read and 0 for write. Each byte is followed by one acknowledge clock, so a full transfer has 18 SCL pulses plus the rising SCL of STOP (19 rises).
- R6: SDA changes only while SCL is low, except for the START and STOP edges. SDA is sampled only while SCL is high.
- R7: The SCL period in clocks is 4·floor(CLK_HZ/(4·rate)). At 50 MHz this is 500 clocks with fast = 0 and 124 clocks with fast = 1. The speed is latched when the request is taken.
- R8: A write sends wdata MSB first. A low SDA in the data acknowledge slot means ACK. A high SDA there sets nack_err.
- R9: A read puts the received byte on rdata (MSB received first). The controller leaves SDA released (NACK) in the acknowledge slot after that byte.
- R10: A high SDA in the address acknowledge slot skips the data byte. STOP follows at once (10 SCL rises in total) and nack_err is set. nack_err holds until the next accepted request clears it.
- R11: While the controller has released SCL but SCL reads low (slave stretching), the quarter timer does not advance.
- R12: Outputs are drive-low enables only. Both are 0 whenever busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs | input | 1 | Chip select for a request |
| rd | input | 1 | Read request strobe |
| wr | input | 1 | Write request strobe |
| addr | input | 3 | Device address (low address bits) |
| wdata | input | 8 | Byte to send on a write |
| fast | input | 1 | 1 selects 400 kbit/s, 0 selects 100 kbit/s |
| rdata | output | 8 | Byte received by the last read |
| busy | output | 1 | Transfer in progress |
| req_err | output | 1 | One-cycle pulse on an illegal request |
| nack_err | output | 1 | Sticky missing-acknowledge status |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The bench drives a model of a slave that can refuse the address, refuse the data byte or stretch every low SCL phase. It checks the result of each transfer against a queue of expected results. The address refusal checks that no data clocks follow. A design that carries on into the data byte shows 19 SCL rises instead of 10 and leaves nack_err clear. Stretching is compared with an identical unstretched read. A timer that ignores the held line either corrupts the byte or finishes no later than the baseline. Other checks cover both strobes at once, a request while SDA is held low, and the SCL period at each speed. These catch a design that starts anyway, raises the error for longer than one cycle, or derives the wrong quarter length.

// File: rtl/i2c1_pkg.sv
package i2c1_pkg;

  typedef enum logic [2:0] {
    SEG_IDLE,
    SEG_START,
    SEG_ADDR,
    SEG_DATA,
    SEG_STOP
  } seg_e;

  // clocks per quarter of an SCL period
  function automatic int unsigned quarter_len(input int unsigned clk_hz,
                                              input int unsigned bit_hz);
    return clk_hz / (4 * bit_hz);
  endfunction

  // first byte on the wire: prefix, device bits, direction (1 = read)
  function automatic logic [7:0] head_byte(input logic [3:0] pfx,
                                           input logic [2:0] dev,
                                           input logic       rd_dir);
    return {pfx, dev, rd_dir};
  endfunction

  // whether the master pulls SDA low for the bit slot now starting
  function automatic logic bit_pulls_low(input seg_e       seg,
                                         input logic       rd_dir,
                                         input logic [3:0] bitn,
                                         input logic       msb);
    return (bitn < 4'd8) && !(seg == SEG_DATA && rd_dir) && !msb;
  endfunction

endpackage

// File: rtl/i2c1_qtimer.sv
module i2c1_qtimer #(
  parameter int unsigned Q_SLOW = 125,
  parameter int unsigned Q_FAST = 31
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic fast,
  input  logic run,
  input  logic scl_rel,
  input  logic scl_in,
  output logic tick
);
  localparam int unsigned QMAX = (Q_SLOW > Q_FAST) ? Q_SLOW : Q_FAST;
  localparam int CW = $clog2(QMAX + 1);

  logic          fast_q;
  logic [CW-1:0] cnt;
  logic          hold;

  function automatic logic [CW-1:0] reload(input logic f);
    return f ? CW'(Q_FAST - 1) : CW'(Q_SLOW - 1);
  endfunction

  // a released SCL that still reads low belongs to a stretching slave
  assign hold = run && scl_rel && !scl_in;
  assign tick = run && !hold && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fast_q <= 1'b0;
      cnt    <= '0;
    end else if (load) begin
      fast_q <= fast;
      cnt    <= reload(fast);
    end else if (tick) begin
      cnt <= reload(fast_q);
    end else if (run && !hold) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/i2c1_hostport.sv
module i2c1_hostport (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic rd,
  input  logic wr,
  input  logic idle,
  input  logic scl_in,
  input  logic sda_in,
  output logic accept,
  output logic req_err
);
  logic illegal;

  assign illegal = cs && rd && wr;
  assign accept  = idle && cs && (rd ^ wr) && scl_in && sda_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_err <= 1'b0;
    else        req_err <= illegal;
  end
endmodule

// File: rtl/i2c1_seq.sv
module i2c1_seq
  import i2c1_pkg::*;
#(
  parameter logic [3:0] ADDR_PREFIX = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic       req_rd,
  input  logic [2:0] req_addr,
  input  logic [7:0] req_wdata,
  input  logic       tick,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       busy,
  output logic [7:0] rdata,
  output logic       nack_err,
  output logic       sample_en,
  output logic       framing
);
  seg_e       seg;
  logic [1:0] q;
  logic [3:0] bitn;
  logic [7:0] sh;
  logic [7:0] dbyte;
  logic       rw;
  logic       ack_bad;
  logic       in_byte;

  assign in_byte   = (seg == SEG_ADDR) || (seg == SEG_DATA);
  assign busy      = (seg != SEG_IDLE);
  assign framing   = (seg == SEG_START) || (seg == SEG_STOP);
  assign sample_en = tick && in_byte && (q == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg      <= SEG_IDLE;
      q        <= 2'd0;
      bitn     <= 4'd0;
      sh       <= 8'h00;
      dbyte    <= 8'h00;
      rw       <= 1'b0;
      ack_bad  <= 1'b0;
      scl_oe   <= 1'b0;
      sda_oe   <= 1'b0;
      nack_err <= 1'b0;
      rdata    <= 8'h00;
    end else if (accept) begin
      seg      <= SEG_START;
      q        <= 2'd0;
      bitn     <= 4'd0;
      rw       <= req_rd;
      sh       <= head_byte(ADDR_PREFIX, req_addr, req_rd);
      dbyte    <= req_wdata;
      ack_bad  <= 1'b0;
      nack_err <= 1'b0;
    end else if (tick) begin
      q <= q + 2'd1;
      case (seg)
        SEG_START: begin
          if (q == 2'd0) begin
            sda_oe <= 1'b1;              // START: SDA falls with SCL high
          end else begin
            scl_oe <= 1'b1;
            seg    <= SEG_ADDR;
            q      <= 2'd0;
            bitn   <= 4'd0;
          end
        end
        SEG_ADDR, SEG_DATA: begin
          case (q)
            2'd0: sda_oe <= bit_pulls_low(seg, rw, bitn, sh[7]);
            2'd1: scl_oe <= 1'b0;
            2'd2: begin
              if (bitn < 4'd8) begin
                sh <= {sh[6:0], sda_in};
                if (seg == SEG_DATA && rw && bitn == 4'd7)
                  rdata <= {sh[6:0], sda_in};
              end else begin
                ack_bad <= sda_in;
              end
            end
            default: begin
              scl_oe <= 1'b1;
              if (bitn != 4'd8) begin
                bitn <= bitn + 4'd1;
              end else begin
                bitn <= 4'd0;
                if (seg == SEG_ADDR) begin
                  if (ack_bad) begin
                    nack_err <= 1'b1;
                    seg      <= SEG_STOP;
                  end else begin
                    seg <= SEG_DATA;
                    sh  <= dbyte;
                  end
                end else begin
                  if (!rw && ack_bad) nack_err <= 1'b1;
                  seg <= SEG_STOP;
                end
              end
            end
          endcase
        end
        SEG_STOP: begin
          case (q)
            2'd0:    sda_oe <= 1'b1;
            2'd1:    scl_oe <= 1'b0;
            2'd2:    sda_oe <= 1'b0;     // STOP: SDA rises with SCL high
            default: seg    <= SEG_IDLE;
          endcase
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_one_byte_ctrl.sv
module i2c_one_byte_ctrl
  import i2c1_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned STD_HZ      = 100_000,
  parameter int unsigned FAST_HZ     = 400_000,
  parameter logic [3:0]  ADDR_PREFIX = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs,
  input  logic       rd,
  input  logic       wr,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  input  logic       fast,
  output logic [7:0] rdata,
  output logic       busy,
  output logic       req_err,
  output logic       nack_err,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe
);
  localparam int unsigned Q_SLOW = quarter_len(CLK_HZ, STD_HZ);
  localparam int unsigned Q_FAST = quarter_len(CLK_HZ, FAST_HZ);

  logic accept;
  logic tick;
  logic sample_en;
  logic framing;

  i2c1_hostport u_host (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs     (cs),
    .rd     (rd),
    .wr     (wr),
    .idle   (!busy),
    .scl_in (scl_in),
    .sda_in (sda_in),
    .accept (accept),
    .req_err(req_err)
  );

  i2c1_qtimer #(.Q_SLOW(Q_SLOW), .Q_FAST(Q_FAST)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .fast   (fast),
    .run    (busy),
    .scl_rel(!scl_oe),
    .scl_in (scl_in),
    .tick   (tick)
  );

  i2c1_seq #(.ADDR_PREFIX(ADDR_PREFIX)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .req_rd   (rd),
    .req_addr (addr),
    .req_wdata(wdata),
    .tick     (tick),
    .sda_in   (sda_in),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .busy     (busy),
    .rdata    (rdata),
    .nack_err (nack_err),
    .sample_en(sample_en),
    .framing  (framing)
  );
endmodule

// File: rtl/i2c1_checker.sv
module i2c1_checker (
  input logic clk,
  input logic rst_n,
  input logic cs,
  input logic rd,
  input logic wr,
  input logic busy,
  input logic req_err,
  input logic nack_err,
  input logic scl_in,
  input logic sda_in,
  input logic scl_oe,
  input logic sda_oe,
  input logic accept,
  input logic tick,
  input logic sample_en,
  input logic framing
);
  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  assert_illegal_no_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cs && rd && wr) |=> !busy);

  assert_err_from_illegal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> $past(cs && rd && wr));

  assert_bus_free_needed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (!sda_in || !scl_in)) |=> !busy);

  assert_sda_quiet_scl_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !scl_oe && !$past(scl_oe)) |-> $past(framing));

  assert_sample_scl_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> scl_in);

  assert_nack_in_transfer_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nack_err) |-> busy);

  assert_stretch_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !scl_oe && !scl_in) |-> !tick);

  assert_idle_released_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));
endmodule

bind i2c_one_byte_ctrl i2c1_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs       (cs),
  .rd       (rd),
  .wr       (wr),
  .busy     (busy),
  .req_err  (req_err),
  .nack_err (nack_err),
  .scl_in   (scl_in),
  .sda_in   (sda_in),
  .scl_oe   (scl_oe),
  .sda_oe   (sda_oe),
  .accept   (accept),
  .tick     (tick),
  .sample_en(sample_en),
  .framing  (framing)
);

// File: tb/i2c_one_byte_ctrl_bench.sv
`timescale 1ns/1ps
module i2c_one_byte_ctrl_bench;
  localparam logic [3:0] PFX = 4'b1010;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, cs, rd, wr, fast;
  logic [2:0] addr;
  logic [7:0] wdata;
  wire  [7:0] rdata;
  wire        busy, req_err, nack_err, scl_oe, sda_oe;

  logic sl_sda_low = 1'b0;
  logic sl_scl_low = 1'b0;
  logic tb_sda_hold = 1'b0;
  wire  scl_line = !(scl_oe || sl_scl_low);
  wire  sda_line = !(sda_oe || sl_sda_low || tb_sda_hold);

  i2c_one_byte_ctrl u_i2c_one_byte_ctrl (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .fast(fast), .rdata(rdata), .busy(busy),
    .req_err(req_err), .nack_err(nack_err), .scl_in(scl_line),
    .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  int total = 0;
  int bad   = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- slave model (acts at falling clock) ----------------
  logic [2:0] cfg_addr = 3'd0;
  bit         cfg_ack_a = 1, cfg_ack_d = 1;
  logic [7:0] cfg_rbyte = 8'h00;
  int         cfg_stretch = 0;

  int   cyc = 0;
  bit   p_scl = 1, p_sda = 1;
  int   sl_phase = 0, sl_bit = 0, stretch_left = 0;
  logic [7:0] sl_sh = 8'h00, sl_head = 8'h00, sl_got = 8'h00;
  bit   sl_rw = 0, sl_match = 0, mack_seen = 0;
  int   starts = 0, stops = 0, rises = 0, last_rise = 0, sl_period = 0;

  always @(negedge clk) begin
    cyc++;
    if (stretch_left > 0) begin
      stretch_left--;
      if (stretch_left == 0) sl_scl_low = 1'b0;
    end
    if (p_scl && scl_line && p_sda && !sda_line) begin
      starts++; sl_phase = 1; sl_bit = -1; sl_sda_low = 1'b0;
    end else if (p_scl && scl_line && !p_sda && sda_line) begin
      stops++; sl_phase = 0; sl_sda_low = 1'b0;
    end
    if (!p_scl && scl_line) begin
      rises++;
      if (sl_phase == 1 && sl_bit >= 1 && sl_bit <= 7) sl_period = cyc - last_rise;
      last_rise = cyc;
      if (sl_phase != 0 && sl_bit >= 0 && sl_bit < 8 && !(sl_phase == 2 && sl_rw))
        sl_sh = {sl_sh[6:0], sda_line};
      if (sl_phase == 2 && sl_rw && sl_bit == 8) mack_seen = sda_line;
    end
    if (p_scl && !scl_line) begin
      if (cfg_stretch > 0) begin
        sl_scl_low = 1'b1;
        stretch_left = cfg_stretch;
      end
      if (sl_phase != 0) begin
        sl_bit++;
        if (sl_bit == 8) begin
          if (sl_phase == 1) begin
            sl_head  = sl_sh;
            sl_match = (sl_sh[7:1] == {PFX, cfg_addr});
            sl_rw    = sl_sh[0];
            sl_sda_low = sl_match && cfg_ack_a;
          end else if (!sl_rw) begin
            sl_got = sl_sh;
            sl_sda_low = cfg_ack_d;
          end else begin
            sl_sda_low = 1'b0;
          end
        end else if (sl_bit == 9) begin
          sl_bit = 0;
          sl_sda_low = 1'b0;
          if (sl_phase == 1 && sl_match && cfg_ack_a) begin
            sl_phase = 2;
            if (sl_rw) sl_sda_low = !cfg_rbyte[7];
          end else begin
            sl_phase = 0;
          end
        end else if (sl_phase == 2 && sl_rw && sl_bit >= 1) begin
          sl_sda_low = !cfg_rbyte[7 - sl_bit];
        end
      end
    end
    p_scl = scl_line;
    p_sda = sda_line;
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    bit         rd;
    bit         exp_nack;
    logic [7:0] exp_rdata;
    logic [7:0] exp_head;
    logic [7:0] exp_wbyte;
    bit         chk_w;
    int         exp_rises;
  } item_t;
  item_t exp_q[$];

  bit prev_busy = 0;
  int base_s = 0, base_p = 0, base_r = 0, busy_len = 0, last_len = 0;

  always @(negedge clk) begin
    if (busy) busy_len++;
    if (busy && !prev_busy) begin
      base_s = starts; base_p = stops; base_r = rises; busy_len = 1;
    end
    if (!busy && prev_busy) begin
      last_len = busy_len;
      if (exp_q.size() == 0) begin
        check(0, "R2 unexpected transfer", 1, 0);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        check(nack_err == it.exp_nack, "R8/R10 nack_err", nack_err, it.exp_nack);
        check(sl_head == it.exp_head, "R5 head byte", sl_head, it.exp_head);
        check(starts - base_s == 1, "R5 one START", starts - base_s, 1);
        check(stops - base_p == 1, "R5 one STOP", stops - base_p, 1);
        check(rises - base_r == it.exp_rises, "R5/R10 SCL rises", rises - base_r, it.exp_rises);
        if (it.rd && !it.exp_nack) begin
          check(rdata == it.exp_rdata, "R9 rdata", rdata, it.exp_rdata);
          check(mack_seen == 1'b1, "R9 master NACK", mack_seen, 1);
        end
        if (it.chk_w) check(sl_got == it.exp_wbyte, "R8 written byte", sl_got, it.exp_wbyte);
        check(scl_line && sda_line, "R12 lines released", {scl_line, sda_line}, 3);
      end
    end
    prev_busy = busy;
  end

  task automatic xfer(input bit rd_i, input logic [2:0] a, input logic [7:0] d,
                      input bit f, input logic [2:0] sa, input bit ack_a,
                      input bit ack_d, input logic [7:0] rb, input int stretch);
    item_t it;
    bit hit;
    cfg_addr = sa; cfg_ack_a = ack_a; cfg_ack_d = ack_d;
    cfg_rbyte = rb; cfg_stretch = stretch; mack_seen = 0;
    hit = (sa == a) && ack_a;
    it.rd        = rd_i;
    it.exp_nack  = !hit || (!rd_i && !ack_d);
    it.exp_rdata = rb;
    it.exp_head  = {PFX, a, rd_i};
    it.exp_wbyte = d;
    it.chk_w     = !rd_i && hit;
    it.exp_rises = hit ? 19 : 10;
    exp_q.push_back(it);
    @(negedge clk);
    cs = 1; rd = rd_i; wr = !rd_i; addr = a; wdata = d; fast = f;
    @(negedge clk);
    check(busy == 1'b1, "R2 busy after accept", busy, 1);
    cs = 0; rd = 0; wr = 0;
    while (busy) @(negedge clk);
    @(negedge clk);
    cfg_stretch = 0;
  endtask

  int base_len = 0;

  initial begin
    rst_n = 0; cs = 0; rd = 0; wr = 0; fast = 0; addr = 0; wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    fork
      begin
        @(negedge clk);
        // R1 reset state
        check(!busy && !req_err && !nack_err, "R1 flags at reset", {busy, req_err, nack_err}, 0);
        check(rdata == 8'h00, "R1 rdata at reset", rdata, 0);
        check(!scl_oe && !sda_oe, "R1 lines released", {scl_oe, sda_oe}, 0);

        // R3 both strobes
        cs = 1; rd = 1; wr = 1;
        @(negedge clk);
        check(req_err == 1'b1, "R3 req_err pulse", req_err, 1);
        check(busy == 1'b0, "R3 no transfer", busy, 0);
        cs = 0; rd = 0; wr = 0;
        @(negedge clk);
        check(req_err == 1'b0, "R3 pulse one cycle", req_err, 0);
        check(!scl_oe && !sda_oe, "R3 bus untouched", {scl_oe, sda_oe}, 0);

        // R4 bus not free
        tb_sda_hold = 1;
        @(negedge clk);
        cs = 1; wr = 1; addr = 3'd2; wdata = 8'h11;
        @(negedge clk);
        cs = 0; wr = 0;
        repeat (4) @(negedge clk);
        check(!busy && !scl_oe && !req_err, "R4 request ignored", {busy, scl_oe, req_err}, 0);
        tb_sda_hold = 0;
        repeat (2) @(negedge clk);

        // slow write with acks (R5, R8, R7)
        xfer(0, 3'd5, 8'hA5, 0, 3'd5, 1, 1, 8'h00, 0);
        check(sl_period == 500, "R7 slow SCL period", sl_period, 500);

        // fast read (R9, R7)
        xfer(1, 3'd3, 8'h00, 1, 3'd3, 1, 1, 8'h3C, 0);
        check(sl_period == 124, "R7 fast SCL period", sl_period, 124);
        base_len = last_len;

        // address refused (R10)
        xfer(0, 3'd1, 8'h77, 1, 3'd6, 1, 1, 8'h00, 0);
        repeat (5) @(negedge clk);
        check(nack_err == 1'b1, "R10 nack_err held", nack_err, 1);

        // data refused on write (R8), other patterns
        xfer(0, 3'd7, 8'h00, 1, 3'd7, 1, 0, 8'h00, 0);
        xfer(0, 3'd0, 8'hFF, 1, 3'd0, 1, 1, 8'h00, 0);
        // accepted read clears nack_err (R10)
        xfer(1, 3'd4, 8'h00, 1, 3'd4, 1, 1, 8'h81, 0);

        // stretching slave (R11)
        xfer(1, 3'd3, 8'h00, 1, 3'd3, 1, 1, 8'h3C, 200);
        check(last_len > base_len + 1900, "R11 stretch lengthens transfer", last_len, base_len + 1900);
        check(exp_q.size() == 0, "R2 all transfers seen", exp_q.size(), 0);
      end
      begin
        while (cyc < 190000) @(negedge clk);
        check(0, "R2 watchdog expired", cyc, 0);
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule